// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access-Rights Check

This block caches virtual-to-physical page translations in a small table where any translation may sit in any slot. A lookup presents a virtual address with an access kind (read, write or execute). One clock later the block reports one of three outcomes. A hit returns the physical address, built from the stored physical page number and the untouched page offset. A miss means no valid slot holds the page, and an outside agent must then fetch the translation. A fault means a slot matched but its rights forbid the access.

A refill port installs a translation taken from the page table. If the page is already cached, the refill overwrites that slot. Otherwise it takes a victim slot: the first invalid slot, else the lowest slot whose referenced flag is clear, else the slot named by a rotating pointer. Every slot keeps a dirty flag and a referenced flag. An access that completes as a hit updates them. A clear input drops every referenced flag at once, so that software can later read them back to approximate least-recently-used order. Each lookup response also reports the slot it matched and that slot's dirty and referenced flags as they stood before the lookup.

Top module: `tlb_fa`

## Requirements
- R1: Any slot of the table can hold any page. With all 32 slots filled by distinct pages, every one of them hits.
- R2: `rsp_valid` rises on the clock edge that samples `lk_valid`. On a hit, `rsp_paddr` is the stored physical page number joined to the 12 low bits of `lk_vaddr`, which are unchanged.
- R3: After reset every slot is invalid. A lookup whose page matches no valid slot reports `rsp_miss`, and exactly one of hit, miss and fault is set in each response.
- R4: Rights encoding: 0 none, 1 read-only, 2 execute (read and execute), 3 read-write (read and write). Access kind encoding: 0 read, 1 write, 2 execute. A matching lookup that its rights forbid reports `rsp_fault` and not `rsp_hit`.
- R5: A hit sets the slot's referenced flag. A fault or miss leaves it unchanged. `ref_clr` clears all referenced flags. If a clear and a hit fall in the same cycle, the hit slot ends up referenced.
- R6: A write hit sets the slot's dirty flag. A faulting write leaves it unchanged. `rsp_dirty` and `rsp_ref` report the slot's flags from before the lookup, and `rsp_slot` gives the matched slot index (0 on a miss).
- R7: A refill of an absent page goes into the lowest-numbered invalid slot, with the referenced flag cleared and the dirty flag taken from `fill_dirty`.
- R8: When no slot is invalid, a refill takes the lowest-numbered slot whose referenced flag is clear.
- R9: When every slot is valid and referenced, a refill takes the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one only on such a refill.
- R10: A refill of a page already present overwrites that slot, and no second copy is made.
- R11: A lookup and a refill in the same cycle: the lookup sees the table as it was before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response present (one cycle after lookup) |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No valid slot for the page |
| rsp_fault | output | 1 | Slot found, access forbidden |
| rsp_paddr | output | 32 | Physical address on hit |
| rsp_slot | output | 5 | Matched slot index |
| rsp_dirty | output | 1 | Matched slot's dirty flag before this lookup |
| rsp_ref | output | 1 | Matched slot's referenced flag before this lookup |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rights | input | 2 | Rights of the new slot (encoding in R4) |
| fill_dirty | input | 1 | Initial dirty flag of the new slot |
| ref_clr | input | 1 | Clear every referenced flag |

## Verification
A lookup hit and the referenced-flag clear can land in the same cycle and both act on the referenced flags. The bench asserts `ref_clr` in the very cycle it presents a lookup of one cached page. It then reads the flags back through later lookups: the looked-up page must report referenced, and another page must report cleared. A refill and a lookup of the same absent page are also driven together. The lookup must miss, and a following lookup must hit in the slot that the victim order predicts.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    RGT_NONE = 2'd0,
    RGT_RO   = 2'd1,
    RGT_EX   = 2'd2,
    RGT_RW   = 2'd3
  } rights_e;

  function automatic logic access_ok(input logic [1:0] rights, input logic [1:0] kind);
    logic ok;
    case (kind)
      ACC_READ:  ok = (rights != RGT_NONE);
      ACC_WRITE: ok = (rights == RGT_RW);
      ACC_EXEC:  ok = (rights == RGT_EX);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [VPN_W-1:0]   vpn_tab [ENTRIES],
  input  logic [VPN_W-1:0]   key,
  output logic [ENTRIES-1:0] match,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (vpn_tab[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] refd,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               use_rr
);

  logic [IDX_W-1:0] inv_idx, clr_idx;
  logic             any_inv, any_clr;

  always_comb begin
    inv_idx = '0;
    clr_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) inv_idx = IDX_W'(i);
      if (!refd[i])  clr_idx = IDX_W'(i);
    end
  end

  assign any_inv = ~&valid;
  assign any_clr = ~&refd;

  always_comb begin
    use_rr = 1'b0;
    if (any_inv)      victim = inv_idx;
    else if (any_clr) victim = clr_idx;
    else begin
      victim = rr_ptr;
      use_rr = 1'b1;
    end
  end

  AST_VICTIM_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    any_inv |-> !valid[victim]); // R7
  AST_VICTIM_UNREFERENCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_inv && any_clr) |-> !refd[victim]); // R8

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [IDX_W-1:0] rsp_slot,
  output logic             rsp_dirty,
  output logic             rsp_ref,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_rights,
  input  logic             fill_dirty,
  input  logic             ref_clr
);
  import tlb_pkg::*;

  // Slot state
  logic [ENTRIES-1:0] v_q, v_d, r_q, r_d, d_q, d_d;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_d [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_d [ENTRIES];
  logic [1:0]         rgt_q [ENTRIES];
  logic [1:0]         rgt_d [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;

  // Lookup path
  logic [ENTRIES-1:0] lk_match;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic               lk_ok;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_cam (
    .valid(v_q), .vpn_tab(vpn_q), .key(lk_vaddr[VA_W-1:OFF_W]),
    .match(lk_match), .any(lk_any), .idx(lk_idx)
  );

  assign lk_ok = lk_any && access_ok(rgt_q[lk_idx], lk_kind);

  // Refill path
  logic [ENTRIES-1:0] fl_match;
  logic               fl_any;
  logic [IDX_W-1:0]   fl_idx, vic_idx, fl_slot;
  logic               vic_rr;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fl_cam (
    .valid(v_q), .vpn_tab(vpn_q), .key(fill_vpn),
    .match(fl_match), .any(fl_any), .idx(fl_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(v_q), .refd(r_q), .rr_ptr(rr_q),
    .victim(vic_idx), .use_rr(vic_rr)
  );

  assign fl_slot = fl_any ? fl_idx : vic_idx;

  // Next state: clear, then lookup update, then refill (refill wins)
  always_comb begin
    v_d = v_q;
    d_d = d_q;
    r_d = ref_clr ? '0 : r_q;
    rr_d = rr_q;
    for (int i = 0; i < ENTRIES; i++) begin
      vpn_d[i] = vpn_q[i];
      ppn_d[i] = ppn_q[i];
      rgt_d[i] = rgt_q[i];
    end
    if (lk_valid && lk_ok) begin
      r_d[lk_idx] = 1'b1;
      if (lk_kind == ACC_WRITE) d_d[lk_idx] = 1'b1;
    end
    if (fill_valid) begin
      v_d[fl_slot]   = 1'b1;
      r_d[fl_slot]   = 1'b0;
      d_d[fl_slot]   = fill_dirty;
      vpn_d[fl_slot] = fill_vpn;
      ppn_d[fl_slot] = fill_ppn;
      rgt_d[fl_slot] = fill_rights;
      if (!fl_any && vic_rr)
        rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      r_q  <= '0;
      d_q  <= '0;
      rr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
        rgt_q[i] <= '0;
      end
    end else begin
      v_q  <= v_d;
      r_q  <= r_d;
      d_q  <= d_d;
      rr_q <= rr_d;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= vpn_d[i];
        ppn_q[i] <= ppn_d[i];
        rgt_q[i] <= rgt_d[i];
      end
    end
  end

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_slot  <= '0;
      rsp_dirty <= 1'b0;
      rsp_ref   <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit   <= lk_ok;
        rsp_miss  <= !lk_any;
        rsp_fault <= lk_any && !lk_ok;
        rsp_paddr <= {ppn_q[lk_idx], lk_vaddr[OFF_W-1:0]};
        rsp_slot  <= lk_idx;
        rsp_dirty <= lk_any && d_q[lk_idx];
        rsp_ref   <= lk_any && r_q[lk_idx];
      end
    end
  end

  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])); // R2
  AST_HIT_MARKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && !$past(fill_valid)) |-> r_q[rsp_slot]); // R5
  AST_WRITE_HIT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && $past(lk_kind) == ACC_WRITE && !$past(fill_valid)) |-> d_q[rsp_slot]); // R6
  AST_FAULT_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> !rsp_hit); // R4

endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref;
  logic [31:0] rsp_paddr;
  logic [4:0]  rsp_slot;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_ppn;
  logic [1:0]  fill_rights;
  logic        fill_dirty;
  logic        ref_clr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlb_fa u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_slot(rsp_slot), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rights(fill_rights), .fill_dirty(fill_dirty), .ref_clr(ref_clr)
  );

  // outcome codes used in the table: 0 hit, 1 miss, 2 fault
  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic [1:0]  res;
    logic [31:0] pa;
    logic [4:0]  slot;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0123, 2'd0, 2'd0, 32'h000A_0123, 5'd0},
    '{32'h0001_0FFF, 2'd1, 2'd2, 32'h0,         5'd0},
    '{32'h0001_0000, 2'd2, 2'd2, 32'h0,         5'd0},
    '{32'h0001_1456, 2'd1, 2'd0, 32'h000A_1456, 5'd1},
    '{32'h0001_1001, 2'd2, 2'd2, 32'h0,         5'd1},
    '{32'h0001_2789, 2'd2, 2'd0, 32'h000A_2789, 5'd2},
    '{32'h0001_2789, 2'd0, 2'd0, 32'h000A_2789, 5'd2},
    '{32'h0001_2000, 2'd1, 2'd2, 32'h0,         5'd2},
    '{32'h0001_3000, 2'd0, 2'd2, 32'h0,         5'd3},
    '{32'h0009_9000, 2'd0, 2'd1, 32'h0,         5'd0}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 1'b0; lk_vaddr = '0; lk_kind = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_rights = '0; fill_dirty = 1'b0;
    ref_clr = 1'b0;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                         input logic [1:0] rgt, input logic dty);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rights = rgt; fill_dirty = dty;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // drives lookup at negedge, samples one time unit after the registering edge
  task automatic do_look(input logic [31:0] va, input logic [1:0] kind);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind;
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
  endtask

  function automatic logic [1:0] outcome();
    return rsp_hit ? 2'd0 : (rsp_miss ? 2'd1 : (rsp_fault ? 2'd2 : 2'd3));
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    #22;
    chk(rsp_valid == 1'b0, "R3 reset rsp_valid", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    do_look(32'h0000_0000, 2'd0);
    chk(rsp_valid && rsp_miss, "R3 empty table miss", {62'd0, rsp_valid, rsp_miss}, 64'd3);

    // R7: fills land in first invalid slots 0..3
    do_fill(20'h00010, 20'h000A0, 2'd1, 1'b0);
    do_fill(20'h00011, 20'h000A1, 2'd3, 1'b0);
    do_fill(20'h00012, 20'h000A2, 2'd2, 1'b0);
    do_fill(20'h00013, 20'h000A3, 2'd0, 1'b0);

    // R2 R4 R7: table of lookups
    for (int k = 0; k < NV; k++) begin
      do_look(VECS[k].va, VECS[k].kind);
      chk(rsp_valid && outcome() == VECS[k].res, "R4 outcome", 64'(outcome()), 64'(VECS[k].res));
      if (VECS[k].res == 2'd0)
        chk(rsp_paddr == VECS[k].pa, "R2 paddr", 64'(rsp_paddr), 64'(VECS[k].pa));
      if (VECS[k].res != 2'd1)
        chk(rsp_slot == VECS[k].slot, "R7 slot", 64'(rsp_slot), 64'(VECS[k].slot));
    end

    // R6: dirty after write hit, unchanged after faulting write
    do_look(32'h0001_1000, 2'd0);
    chk(rsp_dirty == 1'b1, "R6 dirty after write hit", 64'(rsp_dirty), 64'd1);
    do_look(32'h0001_0000, 2'd0);
    chk(rsp_dirty == 1'b0, "R6 dirty kept on fault", 64'(rsp_dirty), 64'd0);
    chk(rsp_ref == 1'b1, "R5 ref set by hit", 64'(rsp_ref), 64'd1);
    do_look(32'h0001_3000, 2'd0);
    chk(rsp_fault && rsp_ref == 1'b0, "R5 fault leaves ref", 64'(rsp_ref), 64'd0);

    // R5: clear alone
    @(negedge clk); ref_clr = 1'b1;
    @(negedge clk); ref_clr = 1'b0;
    do_look(32'h0001_0000, 2'd0);
    chk(rsp_ref == 1'b0, "R5 clear drops ref", 64'(rsp_ref), 64'd0);

    // R5: clear and hit in the same cycle
    @(negedge clk);
    ref_clr = 1'b1; lk_valid = 1'b1; lk_vaddr = 32'h0001_1000; lk_kind = 2'd0;
    @(negedge clk);
    ref_clr = 1'b0; lk_valid = 1'b0;
    do_look(32'h0001_1000, 2'd0);
    chk(rsp_ref == 1'b1, "R5 hit wins over clear", 64'(rsp_ref), 64'd1);
    do_look(32'h0001_0000, 2'd0);
    chk(rsp_ref == 1'b0, "R5 clear hits other slot", 64'(rsp_ref), 64'd0);

    // R10: refill of present page overwrites slot 2
    do_fill(20'h00012, 20'h000B2, 2'd3, 1'b0);
    do_look(32'h0001_2ABC, 2'd1);
    chk(rsp_hit && rsp_paddr == 32'h000B_2ABC, "R10 overwrite paddr", 64'(rsp_paddr), 64'h000B2ABC);
    chk(rsp_slot == 5'd2, "R10 same slot", 64'(rsp_slot), 64'd2);

    // R1 R7: fill the rest, each hits in the next slot
    for (int i = 0; i < 28; i++) begin
      do_fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 2'd3, 1'b0);
    end
    for (int i = 0; i < 28; i++) begin
      do_look({20'h00100 + 20'(i), 12'h055}, 2'd0);
      chk(rsp_hit && rsp_slot == 5'(4 + i), "R1 full table hit", 64'(rsp_slot), 64'(4 + i));
      chk(rsp_paddr == {20'h00200 + 20'(i), 12'h055}, "R1 full table paddr",
          64'(rsp_paddr), 64'({20'h00200 + 20'(i), 12'h055}));
    end

    // R8: only slot 3 unreferenced
    do_fill(20'h00300, 20'h00301, 2'd3, 1'b1);
    do_look(32'h0030_0000, 2'd0);
    chk(rsp_hit && rsp_slot == 5'd3, "R8 lowest unreferenced", 64'(rsp_slot), 64'd3);
    chk(rsp_dirty == 1'b1, "R7 fill dirty loaded", 64'(rsp_dirty), 64'd1);

    // R9: all referenced, rotating pointer 0 then 1
    do_fill(20'h00301, 20'h00401, 2'd3, 1'b0);
    do_look(32'h0030_1000, 2'd0);
    chk(rsp_hit && rsp_slot == 5'd0, "R9 rotate first", 64'(rsp_slot), 64'd0);
    do_look(32'h0001_0000, 2'd0);
    chk(rsp_miss, "R9 evicted page misses", 64'(outcome()), 64'd1);
    do_fill(20'h00302, 20'h00402, 2'd3, 1'b0);
    do_look(32'h0030_2000, 2'd0);
    chk(rsp_hit && rsp_slot == 5'd1, "R9 rotate second", 64'(rsp_slot), 64'd1);

    // R11: refill and lookup of same page together
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00303; fill_ppn = 20'h00403; fill_rights = 2'd3;
    lk_valid = 1'b1; lk_vaddr = 32'h0030_3000; lk_kind = 2'd0;
    @(posedge clk); #1;
    chk(rsp_miss, "R11 lookup sees old table", 64'(outcome()), 64'd1);
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    do_look(32'h0030_3000, 2'd0);
    chk(rsp_hit && rsp_slot == 5'd2, "R11 refill landed", 64'(rsp_slot), 64'd2);

    // R3: reset mid-run empties the table
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_look(32'h0030_3000, 2'd0);
    chk(rsp_miss, "R3 reset invalidates", 64'(outcome()), 64'd1);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule